// File: doc/BRIEF.md
# Dual-Port Radio Frame Buffer with Access Arbitration

This block is a byte buffer placed between a radio baseband and a host controller. The baseband side moves bytes at the air-interface rate. On receive it writes each payload byte and then appends a link-quality byte. On transmit it pulls bytes for the modulator. The host side moves bytes one strobe at a time, to upload a received frame or to download a frame for sending. Each side keeps its own address counter. In framed mode the block compares the two counters whenever the host touches a payload byte. If the host overtakes the baseband, it raises a sticky underrun interrupt.

The length octet never occupies a buffer cell. On receive it is captured with the receive-start strobe, and a framed host read returns it ahead of the payload. On transmit, the first framed host write supplies it. When automatic checksum insertion is on, the last two transmit positions come from an external 16-bit checksum input instead of memory.

A raw mode lets the host read or write any cell from a given start address. Raw mode has no length octet and never flags a violation. After a receive start, framed host reads are held off for a programmable number of clock cycles.

Top module: `frame_buffer_arbiter`

## Requirements
- R1: After reset, `irq_ur`, `h_rvalid` and `tx_dvalid` are all 0.
- R2: After `rx_start`, each `rx_vld` byte is stored at consecutive cells from cell 0. An `rx_end` stores `rx_lqi` in the cell after the last payload byte. The length `rx_len` is kept out of the buffer, so cell 0 holds the first payload byte.
- R3: After a framed `h_start` (`h_raw`=0), the first accepted host read returns the captured receive length. Each later read returns the next cell from cell 0 onward. Read data and `h_rvalid` appear one clock after the `h_rd` strobe.
- R4: After a raw `h_start` (`h_raw`=1), host reads and writes begin at cell `h_addr` and advance by one per access, with no length octet.
- R5: After a framed `h_start`, the first host write sets the transmit length and later writes fill cells from 0. Each `tx_pull` while transmitting yields the next byte on `tx_data`, with `tx_dvalid`, one clock later. Transmission starts at index 0 on `tx_go` and stops after the length is reached.
- R6: With `auto_crc`=1, transmit index length-1 yields `fcs[15:8]` and index length-2 yields `fcs[7:0]`. With `auto_crc`=0, all indices yield stored bytes.
- R7: A framed payload read whose host index is greater than or equal to the baseband index sets `irq_ur`. This uses the counter values before the clock edge, including when the baseband writes in the same cycle.
- R8: A framed payload write while a transmission runs sets `irq_ur` if the host index is less than or equal to the baseband index. A write with a larger host index does not set it.
- R9: In raw mode no access sets `irq_ur`.
- R10: `irq_ur` stays set until `irq_clr`. A new violation in the same cycle as `irq_clr` leaves it set.
- R11: A framed host read is ignored, with no `h_rvalid` and no advance, until `rd_delay` clock edges have passed after the edge that sampled `rx_start`.
- R12: A one-byte payload is handled. On receive it is followed by the quality byte. On transmit with `auto_crc`=1, its single byte is `fcs[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_delay | input | DLY_W | Clock cycles to hold off framed reads after a receive start |
| rx_start | input | 1 | Receive start: resets the baseband index and captures the length |
| rx_len | input | 8 | Received length octet |
| rx_vld | input | 1 | Received payload byte strobe |
| rx_data | input | 8 | Received payload byte |
| rx_end | input | 1 | End of reception: appends the quality byte |
| rx_lqi | input | 8 | Link quality byte |
| tx_go | input | 1 | Transmission start: resets the baseband index |
| tx_pull | input | 1 | Baseband requests the next transmit byte |
| auto_crc | input | 1 | Replace the last two transmit bytes with the checksum |
| fcs | input | 16 | Computed checksum |
| tx_data | output | 8 | Transmit byte |
| tx_dvalid | output | 1 | Transmit byte valid |
| h_raw | input | 1 | Host access mode: 1 raw, 0 framed |
| h_start | input | 1 | Begin a host access sequence |
| h_addr | input | AW | Raw-mode start cell |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe (wins over a read in the same cycle) |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_rvalid | output | 1 | Host read byte valid |
| irq_clr | input | 1 | Clear the underrun interrupt |
| irq_ur | output | 1 | Sticky underrun interrupt |

## Verification
Two events can land on the same edge: a host payload read that reaches the baseband index, and the baseband storing that very byte. The bench strobes `rx_vld` and `h_rd` together when both indices are equal. It expects `irq_ur` set, because the comparison uses the counters before the edge. A violation and an `irq_clr` are also driven on the same edge, and the interrupt is judged to stay high. Random frames of random length, with random checksum settings, are checked in both directions against a bench model of the buffer.

// File: rtl/fb_pkg.sv
package fb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SLOT_MEM = 2'd0,
    SLOT_FCS_LO = 2'd1,
    SLOT_FCS_HI = 2'd2
  } fcs_slot_e;

  // host read has overtaken the baseband writer
  function automatic logic rd_overtake(input int host_idx, input int bb_idx);
    return host_idx >= bb_idx;
  endfunction

  // host write has fallen behind the baseband reader
  function automatic logic wr_lag(input int host_idx, input int bb_idx);
    return host_idx <= bb_idx;
  endfunction

  // choose the transmit byte source for a given index
  function automatic fcs_slot_e fcs_slot(input int idx, input int len, input logic en);
    if (!en) return SLOT_MEM;
    if (idx == len - 1) return SLOT_FCS_HI;
    if (idx == len - 2) return SLOT_FCS_LO;
    return SLOT_MEM;
  endfunction

endpackage

// File: rtl/fb_mem.sv
module fb_mem #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [7:0]    a_wdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_waddr,
  input  logic [7:0]    b_wdata,
  input  logic [AW-1:0] a_raddr,
  input  logic [AW-1:0] b_raddr,
  output logic [7:0]    a_q,
  output logic [7:0]    b_q
);

  logic [7:0] cells [DEPTH];

  // port A (host) written last so it wins a same-cell collision
  always_ff @(posedge clk) begin
    if (b_we) cells[b_waddr] <= b_wdata;
    if (a_we) cells[a_waddr] <= a_wdata;
  end

  assign a_q = cells[a_raddr];
  assign b_q = cells[b_raddr];

endmodule

// File: rtl/fb_bb_port.sv
module fb_bb_port
  import fb_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DLY_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] rd_delay,
  input  logic             rx_start,
  input  logic [7:0]       rx_len,
  input  logic             rx_vld,
  input  logic [7:0]       rx_data,
  input  logic             rx_end,
  input  logic [7:0]       rx_lqi,
  input  logic             tx_go,
  input  logic             tx_pull,
  input  logic [7:0]       tx_len,
  input  logic             auto_crc,
  input  logic [15:0]      fcs,
  input  logic [7:0]       mem_q,
  output logic [CW-1:0]    bb_cnt,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic [7:0]       tx_data,
  output logic             tx_dvalid,
  output logic             tx_busy,
  output logic [7:0]       rx_len_q,
  output logic             rd_open
);

  logic             rx_busy;
  logic [DLY_W-1:0] hold_cnt;
  logic             rx_wr_evt;
  logic             tx_rd_evt;
  fcs_slot_e        slot;
  logic [7:0]       tx_byte;

  assign rx_wr_evt = rx_busy && (rx_vld || rx_end);
  assign tx_rd_evt = tx_busy && tx_pull;
  assign mem_we    = rx_wr_evt && !rx_start && !tx_go;
  assign mem_addr  = bb_cnt[AW-1:0];
  assign mem_wdata = rx_vld ? rx_data : rx_lqi;
  assign rd_open   = (hold_cnt == '0);

  assign slot = fcs_slot(int'(bb_cnt), int'(tx_len), auto_crc);

  always_comb begin
    unique case (slot)
      SLOT_FCS_LO: tx_byte = fcs[7:0];
      SLOT_FCS_HI: tx_byte = fcs[15:8];
      default:     tx_byte = mem_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb_cnt    <= '0;
      rx_busy   <= 1'b0;
      tx_busy   <= 1'b0;
      rx_len_q  <= '0;
      hold_cnt  <= '0;
      tx_data   <= '0;
      tx_dvalid <= 1'b0;
    end else begin
      tx_dvalid <= 1'b0;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (rx_start) begin
        bb_cnt   <= '0;
        rx_busy  <= 1'b1;
        tx_busy  <= 1'b0;
        rx_len_q <= rx_len;
        hold_cnt <= rd_delay;
      end else if (tx_go) begin
        bb_cnt  <= '0;
        tx_busy <= 1'b1;
        rx_busy <= 1'b0;
      end else begin
        if (rx_wr_evt) begin
          bb_cnt <= bb_cnt + 1'b1;
          if (!rx_vld) rx_busy <= 1'b0;
        end
        if (tx_rd_evt) begin
          tx_data   <= tx_byte;
          tx_dvalid <= 1'b1;
          bb_cnt    <= bb_cnt + 1'b1;
          if (int'(bb_cnt) + 1 >= int'(tx_len)) tx_busy <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/fb_host_port.sv
module fb_host_port
  import fb_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_raw,
  input  logic          h_start,
  input  logic [AW-1:0] h_addr,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [7:0]    h_wdata,
  input  logic          irq_clr,
  input  logic [CW-1:0] bb_cnt,
  input  logic          tx_busy,
  input  logic          rd_open,
  input  logic [7:0]    rx_len_q,
  input  logic [7:0]    mem_q,
  output logic [7:0]    h_rdata,
  output logic          h_rvalid,
  output logic          irq_ur,
  output logic [7:0]    tx_len,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          viol_evt
);

  logic [CW-1:0] h_cnt;
  logic          len_phase;
  logic          wr_fire, rd_fire;
  logic          wr_payload, rd_payload;
  logic          rd_viol, wr_viol;

  assign wr_fire    = h_wr && !h_start;
  assign rd_fire    = h_rd && !h_wr && !h_start && (h_raw || rd_open);
  assign wr_payload = wr_fire && (h_raw || !len_phase);
  assign rd_payload = rd_fire && (h_raw || !len_phase);

  assign rd_viol  = rd_payload && !h_raw && rd_overtake(int'(h_cnt), int'(bb_cnt));
  assign wr_viol  = wr_payload && !h_raw && tx_busy && wr_lag(int'(h_cnt), int'(bb_cnt));
  assign viol_evt = rd_viol || wr_viol;

  assign mem_we    = wr_payload;
  assign mem_addr  = h_cnt[AW-1:0];
  assign mem_wdata = h_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt     <= '0;
      len_phase <= 1'b0;
      h_rdata   <= '0;
      h_rvalid  <= 1'b0;
      tx_len    <= '0;
    end else begin
      h_rvalid <= 1'b0;
      if (h_start) begin
        h_cnt     <= h_raw ? {1'b0, h_addr} : '0;
        len_phase <= !h_raw;
      end else begin
        if (wr_fire) begin
          if (wr_payload) begin
            h_cnt <= h_cnt + 1'b1;
          end else begin
            tx_len    <= h_wdata;
            len_phase <= 1'b0;
          end
        end
        if (rd_fire) begin
          h_rvalid <= 1'b1;
          if (rd_payload) begin
            h_rdata <= mem_q;
            h_cnt   <= h_cnt + 1'b1;
          end else begin
            h_rdata   <= rx_len_q;
            len_phase <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_ur <= 1'b0;
    else if (viol_evt) irq_ur <= 1'b1;
    else if (irq_clr) irq_ur <= 1'b0;
  end

endmodule

// File: rtl/frame_buffer_arbiter.sv
module frame_buffer_arbiter #(
  parameter int DEPTH = 128,
  parameter int DLY_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] rd_delay,
  input  logic             rx_start,
  input  logic [7:0]       rx_len,
  input  logic             rx_vld,
  input  logic [7:0]       rx_data,
  input  logic             rx_end,
  input  logic [7:0]       rx_lqi,
  input  logic             tx_go,
  input  logic             tx_pull,
  input  logic             auto_crc,
  input  logic [15:0]      fcs,
  output logic [7:0]       tx_data,
  output logic             tx_dvalid,
  input  logic             h_raw,
  input  logic             h_start,
  input  logic [AW-1:0]    h_addr,
  input  logic             h_rd,
  input  logic             h_wr,
  input  logic [7:0]       h_wdata,
  output logic [7:0]       h_rdata,
  output logic             h_rvalid,
  input  logic             irq_clr,
  output logic             irq_ur
);

  logic [CW-1:0] bb_cnt;
  logic          rd_open;
  logic          viol_evt;
  logic          tx_busy;
  logic [7:0]    tx_len;
  logic [7:0]    rx_len_q;

  logic          h_we, b_we;
  logic [AW-1:0] h_maddr, b_maddr;
  logic [7:0]    h_mwdata, b_mwdata;
  logic [7:0]    h_mq, b_mq;

  fb_mem #(.DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .a_we    (h_we),
    .a_waddr (h_maddr),
    .a_wdata (h_mwdata),
    .b_we    (b_we),
    .b_waddr (b_maddr),
    .b_wdata (b_mwdata),
    .a_raddr (h_maddr),
    .b_raddr (b_maddr),
    .a_q     (h_mq),
    .b_q     (b_mq)
  );

  fb_bb_port #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_bb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_delay  (rd_delay),
    .rx_start  (rx_start),
    .rx_len    (rx_len),
    .rx_vld    (rx_vld),
    .rx_data   (rx_data),
    .rx_end    (rx_end),
    .rx_lqi    (rx_lqi),
    .tx_go     (tx_go),
    .tx_pull   (tx_pull),
    .tx_len    (tx_len),
    .auto_crc  (auto_crc),
    .fcs       (fcs),
    .mem_q     (b_mq),
    .bb_cnt    (bb_cnt),
    .mem_we    (b_we),
    .mem_addr  (b_maddr),
    .mem_wdata (b_mwdata),
    .tx_data   (tx_data),
    .tx_dvalid (tx_dvalid),
    .tx_busy   (tx_busy),
    .rx_len_q  (rx_len_q),
    .rd_open   (rd_open)
  );

  fb_host_port #(.DEPTH(DEPTH)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_raw     (h_raw),
    .h_start   (h_start),
    .h_addr    (h_addr),
    .h_rd      (h_rd),
    .h_wr      (h_wr),
    .h_wdata   (h_wdata),
    .irq_clr   (irq_clr),
    .bb_cnt    (bb_cnt),
    .tx_busy   (tx_busy),
    .rd_open   (rd_open),
    .rx_len_q  (rx_len_q),
    .mem_q     (h_mq),
    .h_rdata   (h_rdata),
    .h_rvalid  (h_rvalid),
    .irq_ur    (irq_ur),
    .tx_len    (tx_len),
    .mem_we    (h_we),
    .mem_addr  (h_maddr),
    .mem_wdata (h_mwdata),
    .viol_evt  (viol_evt)
  );

endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_rd,
  input logic          h_wr,
  input logic          h_raw,
  input logic          h_start,
  input logic          h_rvalid,
  input logic          tx_pull,
  input logic          tx_dvalid,
  input logic          irq_ur,
  input logic          irq_clr,
  input logic          rd_open,
  input logic          viol_evt,
  input logic [CW-1:0] bb_cnt
);

  p_rvalid_needs_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> $past(h_rd));

  p_txvalid_needs_pull_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dvalid |-> $past(tx_pull));

  p_viol_sets_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> irq_ur);

  p_raw_never_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    h_raw |-> !viol_evt);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ur && !irq_clr) |=> irq_ur);

  p_clear_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !viol_evt) |=> !irq_ur);

  p_gate_blocks_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !h_wr && !h_start && !h_raw && !rd_open) |=> !h_rvalid);

  p_bb_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bb_cnt) <= DEPTH);

endmodule

bind frame_buffer_arbiter fb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .h_rd      (h_rd),
  .h_wr      (h_wr),
  .h_raw     (h_raw),
  .h_start   (h_start),
  .h_rvalid  (h_rvalid),
  .tx_pull   (tx_pull),
  .tx_dvalid (tx_dvalid),
  .irq_ur    (irq_ur),
  .irq_clr   (irq_clr),
  .rd_open   (rd_open),
  .viol_evt  (viol_evt),
  .bb_cnt    (bb_cnt)
);

// File: tb/tb_frame_buffer_arbiter.sv
module tb_frame_buffer_arbiter;

  localparam int DEPTH = 128;
  localparam int DLY_W = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DLY_W-1:0] rd_delay = '0;
  logic rx_start = 0, rx_vld = 0, rx_end = 0;
  logic [7:0] rx_len = 0, rx_data = 0, rx_lqi = 0;
  logic tx_go = 0, tx_pull = 0, auto_crc = 0;
  logic [15:0] fcs = 0;
  logic [7:0] tx_data;
  logic tx_dvalid;
  logic h_raw = 0, h_start = 0, h_rd = 0, h_wr = 0, irq_clr = 0;
  logic [AW-1:0] h_addr = 0;
  logic [7:0] h_wdata = 0, h_rdata;
  logic h_rvalid, irq_ur;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] pay [DEPTH];

  always #5 clk = ~clk;

  frame_buffer_arbiter #(.DEPTH(DEPTH), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .rd_delay(rd_delay),
    .rx_start(rx_start), .rx_len(rx_len), .rx_vld(rx_vld), .rx_data(rx_data),
    .rx_end(rx_end), .rx_lqi(rx_lqi), .tx_go(tx_go), .tx_pull(tx_pull),
    .auto_crc(auto_crc), .fcs(fcs), .tx_data(tx_data), .tx_dvalid(tx_dvalid),
    .h_raw(h_raw), .h_start(h_start), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .irq_clr(irq_clr), .irq_ur(irq_ur)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_tx(input int i, input int len, input bit ac, input logic [15:0] f);
    if (ac && i == len - 1) return int'(f[15:8]);
    if (ac && i == len - 2) return int'(f[7:0]);
    return int'(pay[i]);
  endfunction

  // every task is entered and left at a falling edge
  task automatic rx_frame(input int len, input logic [7:0] lqi);
    rx_start = 1; rx_len = 8'(len);
    @(negedge clk); rx_start = 0;
    for (int i = 0; i < len; i++) begin
      rx_vld = 1; rx_data = pay[i];
      @(negedge clk);
    end
    rx_vld = 0; rx_end = 1; rx_lqi = lqi;
    @(negedge clk); rx_end = 0;
  endtask

  task automatic hstart(input bit raw, input int addr);
    h_raw = raw; h_start = 1; h_addr = AW'(addr);
    @(negedge clk); h_start = 0;
  endtask

  task automatic hread(output int d, output bit v);
    h_rd = 1;
    @(negedge clk); h_rd = 0;
    v = h_rvalid; d = int'(h_rdata);
  endtask

  task automatic hwrite(input int b);
    h_wr = 1; h_wdata = 8'(b);
    @(negedge clk); h_wr = 0;
  endtask

  task automatic pull(output int d, output bit v);
    tx_pull = 1;
    @(negedge clk); tx_pull = 0;
    v = tx_dvalid; d = int'(tx_data);
  endtask

  task automatic pulse_go();
    tx_go = 1; @(negedge clk); tx_go = 0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int d, len;
    bit v;
    logic [7:0] lqi;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "irq after reset", int'(irq_ur), 0);
    check("R1", "rvalid after reset", int'(h_rvalid), 0);
    check("R1", "tx_dvalid after reset", int'(tx_dvalid), 0);

    // directed receive, raw and framed upload
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'h30 + i);
    rx_frame(4, 8'hA5);
    hstart(1, 0);
    for (int i = 0; i < 5; i++) begin
      hread(d, v);
      check("R2", "raw read stored cell", d, (i < 4) ? int'(pay[i]) : 'hA5);
    end
    hstart(1, 2);
    hread(d, v);
    check("R4", "raw read from start address 2", d, int'(pay[2]));
    hstart(0, 0);
    hread(d, v);
    check("R3", "framed first read is length", d, 4);
    check("R3", "framed read valid", int'(v), 1);
    for (int i = 0; i < 5; i++) begin
      hread(d, v);
      check("R3", "framed payload/lqi", d, (i < 4) ? int'(pay[i]) : 'hA5);
    end
    check("R7", "no flag on in-bounds read", int'(irq_ur), 0);

    // R11 read gate
    rd_delay = 16'd5;
    rx_start = 1; rx_len = 8'd9;
    @(negedge clk); rx_start = 0;
    hstart(0, 0);
    hread(d, v);
    check("R11", "gated read gives no valid", int'(v), 0);
    repeat (8) @(negedge clk);
    hread(d, v);
    check("R11", "read after delay valid", int'(v), 1);
    check("R11", "gated read did not consume length", d, 9);
    rd_delay = '0;

    // R7 read overtake
    rx_start = 1; rx_len = 8'd5;
    @(negedge clk); rx_start = 0;
    for (int i = 0; i < 2; i++) begin
      rx_vld = 1; rx_data = 8'(8'h60 + i); @(negedge clk);
    end
    rx_vld = 0;
    hstart(0, 0);
    hread(d, v); hread(d, v); hread(d, v);
    check("R7", "no flag while host behind", int'(irq_ur), 0);
    hread(d, v);
    check("R7", "flag when host index equals baseband", int'(irq_ur), 1);
    repeat (4) @(negedge clk);
    check("R10", "flag stays set", int'(irq_ur), 1);
    pulse_clr();
    check("R10", "clear drops flag", int'(irq_ur), 0);

    // same-cycle: baseband stores the byte the host reads
    hstart(0, 0);
    hread(d, v); hread(d, v); hread(d, v);
    check("R7", "flag clear before same-cycle case", int'(irq_ur), 0);
    rx_vld = 1; rx_data = 8'h62; h_rd = 1;
    @(negedge clk); rx_vld = 0; h_rd = 0;
    check("R7", "same-cycle read/store flags", int'(irq_ur), 1);
    // violation together with clear: set wins
    h_rd = 1; irq_clr = 1;
    @(negedge clk); h_rd = 0; irq_clr = 0;
    check("R10", "violation beats clear", int'(irq_ur), 1);
    pulse_clr();

    // R9 raw read past the baseband index
    hstart(1, 100);
    hread(d, v);
    check("R9", "raw read past writer no flag", int'(irq_ur), 0);

    // R8 write lag during transmission
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h90 + i);
    auto_crc = 0;
    hstart(0, 0);
    hwrite(6);
    for (int i = 0; i < 3; i++) hwrite(pay[i]);
    pulse_go();
    pull(d, v);
    check("R5", "tx byte 0", d, int'(pay[0]));
    check("R5", "tx valid", int'(v), 1);
    hwrite(pay[3]);
    check("R8", "write ahead of reader no flag", int'(irq_ur), 0);
    for (int i = 1; i < 4; i++) begin
      pull(d, v);
      check("R5", "tx stored byte", d, int'(pay[i]));
    end
    hwrite(pay[4]);
    check("R8", "write at reader index flags", int'(irq_ur), 1);
    pulse_clr();
    hstart(1, 0);
    hwrite(8'h11);
    check("R9", "raw write during tx no flag", int'(irq_ur), 0);
    pull(d, v);
    check("R5", "tx byte 4", d, int'(pay[4]));
    pull(d, v);
    pull(d, v);
    check("R5", "no byte past length", int'(v), 0);

    // R12 one-byte frames
    pay[0] = 8'h7E;
    rx_frame(1, 8'h33);
    hstart(0, 0);
    hread(d, v); check("R12", "len-1 length octet", d, 1);
    hread(d, v); check("R12", "len-1 payload", d, 'h7E);
    hread(d, v); check("R12", "len-1 lqi", d, 'h33);
    auto_crc = 1; fcs = 16'hBEEF;
    hstart(0, 0);
    hwrite(1); hwrite(8'h7E);
    pulse_go();
    pull(d, v);
    check("R12", "len-1 tx with crc high byte", d, 'hBE);
    check("R6", "single byte is checksum high", d, exp_tx(0, 1, 1'b1, 16'hBEEF));

    // random frames both directions
    for (int it = 0; it < 40; it++) begin
      len = 1 + int'($urandom % 30);
      for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
      lqi = 8'($urandom);
      rx_frame(len, lqi);
      hstart(0, 0);
      hread(d, v);
      check("R3", "random length octet", d, len);
      for (int i = 0; i <= len; i++) begin
        hread(d, v);
        check("R2", "random upload byte", d, (i < len) ? int'(pay[i]) : int'(lqi));
      end
      auto_crc = 1'($urandom);
      fcs = 16'($urandom);
      hstart(0, 0);
      hwrite(len);
      for (int i = 0; i < len; i++) hwrite(pay[i]);
      pulse_go();
      for (int i = 0; i < len; i++) begin
        pull(d, v);
        check("R6", "random tx byte", d, exp_tx(i, len, auto_crc, fcs));
      end
      check("R7", "random frame no flag", int'(irq_ur), 0);
    end

    finish_up();
  end

endmodule